// File: doc/BRIEF.md
# Circular Buffer Pointer Updater

This block keeps an address pointer that walks around a circular buffer. The buffer is bounded by two held addresses, a start bound and an end bound. These may come in either order: when the start bound lies above the end bound, the buffer covers the addresses from the end bound up to the start bound. On each update the pointer moves up or down by a given step. Any result that leaves the buffer is folded back inside by adding or subtracting the buffer length once.

An address generator uses it as its modulo-addressing unit. Software or a sequencer loads the two bounds and an initial pointer, then pulses the update strobe once per access. The step and the direction go with each strobe. The pointer output feeds the memory address path directly.

Top module: `circ_ptr_updater`

## Requirements
- R1: While reset is asserted, and at the first edge after it, the pointer, the start bound and the end bound all read zero.
- R2: A load strobe for the start bound, the end bound or the pointer captures its value at the next rising edge. A pointer load takes priority over an update in the same cycle. The other two registers hold when their load strobe is low.
- R3: With neither the update strobe nor the pointer load high, the pointer holds its value.
- R4: On an update the candidate is the pointer plus the step when the direction bit is 0, or the pointer minus the step when it is 1. A candidate that lies within the buffer becomes the new pointer, and a step of zero leaves the pointer unchanged.
- R5: With start below end, the length is end − start + 1. A candidate above end has the length subtracted.
- R6: With start below end, a candidate below start has the length added.
- R7: With start above end, the buffer spans end..start and the length is start − end + 1. A candidate above start has the length subtracted.
- R8: With start above end, a candidate below end has the length added.
- R9: With start equal to end, an update sets the pointer to that address.
- R10: Candidates that fall below address zero or beyond the top of the address range are still folded correctly, because the comparison is made with two extra bits.
- R11: An update uses the bounds held before the edge. A bound loaded in the same cycle takes effect from the next update onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ld_start_i | input | 1 | Load strobe for the start bound |
| start_val_i | input | AW | Start bound value |
| ld_end_i | input | 1 | Load strobe for the end bound |
| end_val_i | input | AW | End bound value |
| ld_ptr_i | input | 1 | Load strobe for the pointer |
| ptr_val_i | input | AW | Pointer load value |
| upd_i | input | 1 | Update strobe |
| step_i | input | AW | Step magnitude |
| dir_down_i | input | 1 | 0 moves up, 1 moves down |
| ptr_o | output | AW | Current pointer |

## Verification
The fold assertion assumes two things at each update. The pointer must already lie inside the buffer, and the step must not exceed the buffer length, so that a single correction lands in range. The assertion is gated on both conditions and stays silent otherwise. The random stimulus meets them: it picks bounds first, then loads a pointer between them and draws steps from zero up to the length. The directed cases that fold past address zero or past the top address also keep to these limits.

// File: rtl/circ_ptr_pkg.sv
package circ_ptr_pkg;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } step_dir_e;

  typedef enum logic [1:0] {
    ORD_ASC    = 2'd0,
    ORD_DESC   = 2'd1,
    ORD_SINGLE = 2'd2
  } bound_order_e;

endpackage

// File: rtl/circ_rst_sync.sv
module circ_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/circ_bound_regs.sv
module circ_bound_regs #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_start_i,
  input  logic [AW-1:0] start_val_i,
  input  logic          ld_end_i,
  input  logic [AW-1:0] end_val_i,
  output logic [AW-1:0] start_o,
  output logic [AW-1:0] end_o
);

  logic [AW-1:0] start_q, start_d;
  logic [AW-1:0] end_q, end_d;

  always_comb begin
    start_d = start_q;
    end_d   = end_q;
    if (ld_start_i) start_d = start_val_i;
    if (ld_end_i)   end_d   = end_val_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      end_q   <= '0;
    end else begin
      start_q <= start_d;
      end_q   <= end_d;
    end
  end

  assign start_o = start_q;
  assign end_o   = end_q;

  AST_START_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_start_i |=> $stable(start_q)); // R2
  AST_END_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_end_i |=> $stable(end_q)); // R2

endmodule

// File: rtl/circ_span.sv
module circ_span
  import circ_ptr_pkg::*;
#(
  parameter int AW = 8,
  localparam int SW = AW + 1
) (
  input  logic [AW-1:0] start_i,
  input  logic [AW-1:0] end_i,
  output bound_order_e  order_o,
  output logic [AW-1:0] lo_o,
  output logic [AW-1:0] hi_o,
  output logic [SW-1:0] len_o
);

  logic [SW-1:0] one_w;
  assign one_w = {{AW{1'b0}}, 1'b1};

  always_comb begin
    if (start_i == end_i) begin
      order_o = ORD_SINGLE;
      lo_o    = start_i;
      hi_o    = start_i;
      len_o   = one_w;
    end else if (start_i < end_i) begin
      order_o = ORD_ASC;
      lo_o    = start_i;
      hi_o    = end_i;
      len_o   = ({1'b0, end_i} - {1'b0, start_i}) + one_w;
    end else begin
      order_o = ORD_DESC;
      lo_o    = end_i;
      hi_o    = start_i;
      len_o   = ({1'b0, start_i} - {1'b0, end_i}) + one_w;
    end
  end

endmodule

// File: rtl/circ_wrap.sv
module circ_wrap
  import circ_ptr_pkg::*;
#(
  parameter int AW = 8,
  localparam int SW = AW + 1,
  localparam int EW = AW + 2
) (
  input  logic [AW-1:0] ptr_i,
  input  logic [AW-1:0] step_i,
  input  step_dir_e     dir_i,
  input  bound_order_e  order_i,
  input  logic [AW-1:0] lo_i,
  input  logic [AW-1:0] hi_i,
  input  logic [SW-1:0] len_i,
  output logic [AW-1:0] next_o
);

  logic signed [EW-1:0] ptr_x, step_x, lo_x, hi_x, len_x, cand_x;
  logic                 past_hi, past_lo;

  assign ptr_x  = {2'b00, ptr_i};
  assign step_x = {2'b00, step_i};
  assign lo_x   = {2'b00, lo_i};
  assign hi_x   = {2'b00, hi_i};
  assign len_x  = {1'b0, len_i};

  assign cand_x  = (dir_i == DIR_DOWN) ? (ptr_x - step_x) : (ptr_x + step_x);
  assign past_hi = cand_x > hi_x;
  assign past_lo = cand_x < lo_x;

  always_comb begin
    if (order_i == ORD_SINGLE) begin
      next_o = lo_i;
    end else if (past_hi) begin
      next_o = AW'(cand_x - len_x);
    end else if (past_lo) begin
      next_o = AW'(cand_x + len_x);
    end else begin
      next_o = AW'(cand_x);
    end
  end

endmodule

// File: rtl/circ_ptr_updater.sv
module circ_ptr_updater
  import circ_ptr_pkg::*;
#(
  parameter int AW = 8,
  localparam int SW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_start_i,
  input  logic [AW-1:0] start_val_i,
  input  logic          ld_end_i,
  input  logic [AW-1:0] end_val_i,
  input  logic          ld_ptr_i,
  input  logic [AW-1:0] ptr_val_i,
  input  logic          upd_i,
  input  logic [AW-1:0] step_i,
  input  logic          dir_down_i,
  output logic [AW-1:0] ptr_o
);

  logic          rst_n_s;
  logic [AW-1:0] start_w, end_w, lo_w, hi_w, wrapped_w;
  logic [SW-1:0] len_w;
  bound_order_e  order_w;
  step_dir_e     dir_w;
  logic [AW-1:0] ptr_q, ptr_d;
  logic          in_buf_w;

  circ_rst_sync #(.STAGES(2)) u_rst (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_n_sync_o (rst_n_s)
  );

  circ_bound_regs #(.AW(AW)) u_bounds (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .ld_start_i  (ld_start_i),
    .start_val_i (start_val_i),
    .ld_end_i    (ld_end_i),
    .end_val_i   (end_val_i),
    .start_o     (start_w),
    .end_o       (end_w)
  );

  circ_span #(.AW(AW)) u_span (
    .start_i (start_w),
    .end_i   (end_w),
    .order_o (order_w),
    .lo_o    (lo_w),
    .hi_o    (hi_w),
    .len_o   (len_w)
  );

  assign dir_w = dir_down_i ? DIR_DOWN : DIR_UP;

  circ_wrap #(.AW(AW)) u_wrap (
    .ptr_i   (ptr_q),
    .step_i  (step_i),
    .dir_i   (dir_w),
    .order_i (order_w),
    .lo_i    (lo_w),
    .hi_i    (hi_w),
    .len_i   (len_w),
    .next_o  (wrapped_w)
  );

  always_comb begin
    ptr_d = ptr_q;
    if (ld_ptr_i) begin
      ptr_d = ptr_val_i;
    end else if (upd_i) begin
      ptr_d = wrapped_w;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ptr_q <= '0;
    end else begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr_o = ptr_q;

  assign in_buf_w = (ptr_q >= lo_w) && (ptr_q <= hi_w);

  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n_s)
    ld_ptr_i |=> ptr_q == $past(ptr_val_i)); // R2
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!ld_ptr_i && !upd_i) |=> $stable(ptr_q)); // R3
  AST_ZERO_STEP: assert property (@(posedge clk) disable iff (!rst_n_s)
    (upd_i && !ld_ptr_i && in_buf_w && step_i == '0) |=> $stable(ptr_q)); // R4
  AST_STAYS_INSIDE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (upd_i && !ld_ptr_i && in_buf_w && ({1'b0, step_i} <= len_w))
      |=> (ptr_q >= $past(lo_w)) && (ptr_q <= $past(hi_w))); // R5
  AST_SINGLE_SLOT: assert property (@(posedge clk) disable iff (!rst_n_s)
    (upd_i && !ld_ptr_i && start_w == end_w) |=> ptr_q == $past(start_w)); // R9

endmodule

// File: tb/circ_ptr_updater_tb.sv
module circ_ptr_updater_tb;

  localparam int AW = 8;
  localparam int AMAX = (1 << AW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ld_start = 1'b0, ld_end = 1'b0, ld_ptr = 1'b0, upd = 1'b0, dn = 1'b0;
  logic [AW-1:0] start_v = '0, end_v = '0, ptr_v = '0, step = '0;
  logic [AW-1:0] ptr_out;

  int n_checks = 0;
  int n_errors = 0;
  int exp_q[$];
  string tag_q[$];
  int m_start = 0, m_end = 0, m_ptr = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  circ_ptr_updater #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .ld_start_i(ld_start), .start_val_i(start_v),
    .ld_end_i(ld_end), .end_val_i(end_v),
    .ld_ptr_i(ld_ptr), .ptr_val_i(ptr_v),
    .upd_i(upd), .step_i(step), .dir_down_i(dn),
    .ptr_o(ptr_out)
  );

  function automatic int model_next(int s, int e, int p, int st, bit down);
    int lo, hi, len, c;
    if (s == e) return s;
    lo = (s < e) ? s : e;
    hi = (s < e) ? e : s;
    len = hi - lo + 1;
    c = down ? p - st : p + st;
    if (c > hi) c = c - len;
    else if (c < lo) c = c + len;
    return c;
  endfunction

  task automatic check(int act, int exp, string tag);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: ptr actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and pushes the expected pointer
  task automatic op(bit ls, int sv, bit le, int ev, bit lp, int pv,
                    bit u, int st, bit d, string tag);
    int nxt;
    @(negedge clk);
    ld_start = ls; start_v = AW'(sv);
    ld_end = le;   end_v = AW'(ev);
    ld_ptr = lp;   ptr_v = AW'(pv);
    upd = u;       step = AW'(st); dn = d;
    if (lp) nxt = pv;
    else if (u) nxt = model_next(m_start, m_end, m_ptr, st, d);
    else nxt = m_ptr;
    if (ls) m_start = sv;
    if (le) m_end = ev;
    m_ptr = nxt;
    exp_q.push_back(nxt);
    tag_q.push_back(tag);
  endtask

  task automatic setup(int s, int e, int p);
    op(1, s, 1, e, 1, p, 0, 0, 0, "R2");
  endtask

  task automatic step_op(int st, bit d, string tag);
    op(0, 0, 0, 0, 0, 0, 1, st, d, tag);
  endtask

  // monitor: compares after each rising edge, away from it
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      check(int'(ptr_out), exp_q.pop_front(), tag_q.pop_front());
    end
  end

  initial begin
    #(8 * 200000);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(int'(ptr_out), 0, "R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(int'(ptr_out), 0, "R1 after reset");
    step_op(5, 0, "R1 R9 zero bounds");

    setup(16, 23, 20);
    step_op(2, 0, "R4 up inside");
    step_op(3, 0, "R5 above end");
    step_op(4, 1, "R6 below start");
    step_op(0, 0, "R4 zero step");
    op(0, 0, 0, 0, 0, 0, 0, 7, 1, "R3 hold");
    op(0, 0, 0, 0, 0, 0, 0, 3, 0, "R3 hold");
    step_op(3, 1, "R4 down inside");
    step_op(8, 0, "R5 full length");

    setup(40, 33, 38);
    step_op(5, 0, "R7 above start");
    step_op(4, 1, "R8 below end");
    step_op(1, 1, "R4 desc inside");

    setup(50, 50, 50);
    step_op(1, 0, "R9 single up");
    op(0, 0, 0, 0, 1, 52, 0, 0, 0, "R2 ptr load");
    step_op(3, 1, "R9 single from outside");

    setup(0, 7, 1);
    step_op(3, 1, "R10 below zero");
    setup(250, AMAX, 254);
    step_op(4, 0, "R10 past top");
    setup(AMAX, 248, 253);
    step_op(8, 0, "R10 R7 desc past top");
    setup(7, 0, 2);
    step_op(5, 1, "R10 R8 desc below zero");

    setup(16, 23, 22);
    op(0, 0, 1, 30, 0, 0, 1, 3, 0, "R11 old end used");
    step_op(10, 0, "R11 new end used");
    op(0, 0, 0, 0, 1, 18, 1, 2, 0, "R2 load beats update");
    op(1, 100, 0, 0, 0, 0, 0, 0, 0, "R2 start load");
    step_op(1, 1, "R2 new start seen");

    for (int i = 0; i < 300; i++) begin
      int a, b, lo, hi, p, st;
      a = int'($urandom_range(0, AMAX));
      b = int'($urandom_range(0, AMAX));
      lo = (a < b) ? a : b;
      hi = (a < b) ? b : a;
      p = int'($urandom_range(lo, hi));
      setup(a, b, p);
      for (int k = 0; k < 4; k++) begin
        st = int'($urandom_range(0, hi - lo + 1));
        step_op(st, bit'($urandom_range(0, 1)), "R4 R5 R6 R7 R8 random");
      end
    end

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule